// File: doc/BRIEF.md
# Power-Fail Access Guard for Battery-Backed SRAM

This block sits between a host and a static memory array that keeps its contents on a backup cell when main power fails. Three digital flags from external supply comparators arrive asynchronously. Each flag says whether the supply is above one of three levels: the run level (full operation), the fail level (the write-lockout point) and the cell level (the point where the array switches to the backup cell). The block resynchronises and filters these flags. It then runs a four-state supply machine and passes the host's active-low chip-enable, write-enable and output-enable strobes to the array only while the supply is healthy.

Once any flag drops, the array strobes are forced inactive and the data drivers are turned off. Below the cell level, the block selects the backup cell as the array's power source. On the way back up, the main supply is selected again as soon as the cell level is regained. Host access returns only after the run level is regained and a configurable recovery hold has elapsed. A status output reports the machine state, and a sticky flag records that a power-fail event occurred since reset.

Top module: `pfg_guard`

## Requirements
- R1: During and after a synchronous reset, status is 2 (BACKUP), the backup-cell select is 1, all three array strobes are high, the data-drive enable is 0 and the sticky fail flag is 0. Status codes are 0 NORMAL, 1 PROTECT, 2 BACKUP and 3 RECOVER.
- R2: Each supply flag passes through SYNC_STAGES flops. A new value must then persist for DEBOUNCE consecutive cycles before the state machine acts on it. A pulse shorter than DEBOUNCE cycles has no effect.
- R3: While the next state is NORMAL, the registered array strobes follow the host one cycle later. Chip enable is passed through. A write is chip enable low with write enable low, whatever output enable does. A read is chip enable low, write enable high and output enable low. The data-drive enable is 1 only for a read.
- R4: In NORMAL, a low run, fail or cell flag ends NORMAL. The array write strobe goes high on the same clock edge at which the state leaves NORMAL, which aborts a write in progress.
- R5: Whenever the status is not NORMAL, all array strobes are high and the data-drive enable is 0, whatever the host inputs do.
- R6: A low cell flag in any state moves the machine to BACKUP with the cell select at 1. When the cell flag returns high, the machine moves from BACKUP to PROTECT with the cell select at 0.
- R7: From PROTECT, the machine moves to RECOVER only when both the run and fail flags are high. A high cell flag alone, or a high cell and fail flag without the run flag, keeps it in PROTECT.
- R8: RECOVER lasts RECOVER_HOLD cycles and then becomes NORMAL. A low run or fail flag during RECOVER returns the machine to PROTECT, and a low cell flag returns it to BACKUP.
- R9: A host write that was blocked while it was being held is not forwarded after NORMAL returns. It stays blocked until the host releases the write, and a later fresh write is forwarded.
- R10: The sticky fail flag is set when the machine leaves NORMAL and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_run_i | input | 1 | Supply above run level (asynchronous) |
| lvl_fail_i | input | 1 | Supply above fail (write-lockout) level (asynchronous) |
| lvl_cell_i | input | 1 | Supply above backup-switch level (asynchronous) |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Array chip enable, active low, registered |
| mem_we_n | output | 1 | Array write enable, active low, registered |
| mem_oe_n | output | 1 | Array output enable, active low, registered |
| dq_drive | output | 1 | Enable for the host-side data drivers |
| src_cell | output | 1 | 1 selects the backup cell as array supply |
| state_o | output | 2 | Supply state code |
| fail_seen | output | 1 | Sticky power-fail indicator |

## Verification
The bench builds the block with SYNC_STAGES 2, DEBOUNCE 3 and RECOVER_HOLD 12. The short filter window lets a two-cycle glitch and a real drop both be shown within a few cycles. The long recovery hold leaves room to drop a flag while the machine is still in RECOVER, and to hold a host write across a whole protect-and-recover episode. A behavioural model in the bench predicts every output on every clock, while directed sequences walk the supply through partial rises, where only some flags return, and through a full collapse to the backup cell.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_GUARD  = 2'd1,
    ST_CELL   = 2'd2,
    ST_SETTLE = 2'd3
  } pwr_state_t;

  localparam int NUM_LEVELS = 3;
  localparam int LVL_CELL   = 0;
  localparam int LVL_FAIL   = 1;
  localparam int LVL_RUN    = 2;
endpackage

// File: rtl/pfg_flag_filter.sv
// Resynchronises one asynchronous comparator flag and accepts a new value
// only after it has held for DEBOUNCE consecutive cycles.
module pfg_flag_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEBOUNCE    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = (DEBOUNCE > 1) ? $clog2(DEBOUNCE) : 1;

  logic [SYNC_STAGES-1:0] chain;
  logic                   synced;
  logic [CW-1:0]          run_cnt;

  assign synced = chain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain <= {chain[SYNC_STAGES-2:0], raw_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clean_o <= 1'b0;
      run_cnt <= '0;
    end else if (synced == clean_o) begin
      run_cnt <= '0;
    end else if (run_cnt == CW'(DEBOUNCE - 1)) begin
      clean_o <= synced;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pfg_supply_fsm.sv
// Supply state machine: NORMAL / PROTECT / BACKUP / RECOVER.
module pfg_supply_fsm
  import pfg_pkg::*;
#(
  parameter int RECOVER_HOLD = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ok_run,
  input  logic       ok_fail,
  input  logic       ok_cell,
  output pwr_state_t state_q,
  output pwr_state_t state_nx,
  output logic       fail_seen_q
);
  localparam int HW = (RECOVER_HOLD > 1) ? $clog2(RECOVER_HOLD) : 1;

  logic [HW-1:0] hold_cnt;
  logic          upper_ok;

  assign upper_ok = ok_run && ok_fail;

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (!ok_cell)       state_nx = ST_CELL;
        else if (!upper_ok) state_nx = ST_GUARD;
      end
      ST_GUARD: begin
        if (!ok_cell)       state_nx = ST_CELL;
        else if (upper_ok)  state_nx = ST_SETTLE;
      end
      ST_CELL: begin
        if (ok_cell)        state_nx = ST_GUARD;
      end
      ST_SETTLE: begin
        if (!ok_cell)       state_nx = ST_CELL;
        else if (!upper_ok) state_nx = ST_GUARD;
        else if (hold_cnt == HW'(RECOVER_HOLD - 1)) state_nx = ST_RUN;
      end
      default: state_nx = ST_CELL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_CELL;
      hold_cnt    <= '0;
      fail_seen_q <= 1'b0;
    end else begin
      state_q  <= state_nx;
      hold_cnt <= (state_q == ST_SETTLE && state_nx == ST_SETTLE) ? hold_cnt + 1'b1 : '0;
      if (state_q == ST_RUN && state_nx != ST_RUN) fail_seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pfg_strobe_gate.sv
// Registers the array strobes from the host strobes, gated by the next state.
module pfg_strobe_gate (
  input  logic clk,
  input  logic rst,
  input  logic pass_i,
  input  logic cell_i,
  input  logic host_ce_n,
  input  logic host_we_n,
  input  logic host_oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic mem_oe_n,
  output logic dq_drive,
  output logic src_cell
);
  logic host_wr;
  logic host_rd;
  logic wr_block;

  assign host_wr = !host_ce_n && !host_we_n;
  assign host_rd = !host_ce_n && host_we_n && !host_oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
      dq_drive <= 1'b0;
      src_cell <= 1'b1;
      wr_block <= 1'b0;
    end else begin
      mem_ce_n <= !(pass_i && !host_ce_n);
      mem_we_n <= !(pass_i && host_wr && !wr_block);
      mem_oe_n <= !(pass_i && host_rd);
      dq_drive <= pass_i && host_rd;
      src_cell <= cell_i;
      wr_block <= host_wr && (wr_block || !pass_i);
    end
  end
endmodule

// File: rtl/pfg_guard.sv
module pfg_guard
  import pfg_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int DEBOUNCE     = 4,
  parameter int RECOVER_HOLD = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl_run_i,
  input  logic       lvl_fail_i,
  input  logic       lvl_cell_i,
  input  logic       host_ce_n,
  input  logic       host_we_n,
  input  logic       host_oe_n,
  output logic       mem_ce_n,
  output logic       mem_we_n,
  output logic       mem_oe_n,
  output logic       dq_drive,
  output logic       src_cell,
  output logic [1:0] state_o,
  output logic       fail_seen
);
  logic [NUM_LEVELS-1:0] lvl_raw;
  logic [NUM_LEVELS-1:0] lvl_ok;
  pwr_state_t            st_q;
  pwr_state_t            st_nx;

  assign lvl_raw[LVL_CELL] = lvl_cell_i;
  assign lvl_raw[LVL_FAIL] = lvl_fail_i;
  assign lvl_raw[LVL_RUN]  = lvl_run_i;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    pfg_flag_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .DEBOUNCE   (DEBOUNCE)
    ) u_filt (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (lvl_raw[g]),
      .clean_o(lvl_ok[g])
    );
  end

  pfg_supply_fsm #(
    .RECOVER_HOLD(RECOVER_HOLD)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .ok_run     (lvl_ok[LVL_RUN]),
    .ok_fail    (lvl_ok[LVL_FAIL]),
    .ok_cell    (lvl_ok[LVL_CELL]),
    .state_q    (st_q),
    .state_nx   (st_nx),
    .fail_seen_q(fail_seen)
  );

  pfg_strobe_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .pass_i   (st_nx == ST_RUN),
    .cell_i   (st_nx == ST_CELL),
    .host_ce_n(host_ce_n),
    .host_we_n(host_we_n),
    .host_oe_n(host_oe_n),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .dq_drive (dq_drive),
    .src_cell (src_cell)
  );

  assign state_o = st_q;
endmodule

// File: rtl/pfg_guard_chk.sv
module pfg_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       mem_ce_n,
  input logic       mem_we_n,
  input logic       mem_oe_n,
  input logic       dq_drive,
  input logic       src_cell,
  input logic [1:0] state_o,
  input logic       fail_seen
);
  // R5: nothing reaches the array outside NORMAL
  assert_quiet_outside_run_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o != 2'd0) |-> (mem_ce_n && mem_we_n && mem_oe_n && !dq_drive));

  // R6: cell select tracks the BACKUP state
  assert_cell_select_R6: assert property (@(posedge clk) disable iff (rst)
    src_cell == (state_o == 2'd2));

  // R6: BACKUP only leaves towards PROTECT
  assert_backup_exit_R6: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2) |=> (state_o == 2'd2 || state_o == 2'd1));

  // R7: PROTECT never returns straight to NORMAL
  assert_no_skip_recover_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1) |=> (state_o != 2'd0));

  // R3: reads and writes never overlap at the array
  assert_rd_wr_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || dq_drive) |-> (mem_we_n && !mem_ce_n));

  // R10: the fail flag is sticky
  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    $past(fail_seen) |-> fail_seen);
endmodule

bind pfg_guard pfg_guard_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_ce_n (mem_ce_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .dq_drive (dq_drive),
  .src_cell (src_cell),
  .state_o  (state_o),
  .fail_seen(fail_seen)
);

// File: tb/tb_pfg_guard.sv
module tb_pfg_guard;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int DEB  = 3;
  localparam int HOLD = 12;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic f_run = 1'b0, f_fail = 1'b0, f_cell = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic mem_ce_n, mem_we_n, mem_oe_n, dq_drive, src_cell, fail_seen;
  logic [1:0] state_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfg_guard #(.SYNC_STAGES(SYNC), .DEBOUNCE(DEB), .RECOVER_HOLD(HOLD)) dut (
    .clk(clk), .rst(rst),
    .lvl_run_i(f_run), .lvl_fail_i(f_fail), .lvl_cell_i(f_cell),
    .host_ce_n(ce_n), .host_we_n(we_n), .host_oe_n(oe_n),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .dq_drive(dq_drive), .src_cell(src_cell), .state_o(state_o),
    .fail_seen(fail_seen));

  // ---------------- behavioural reference model ----------------
  int s1[3], s2[3], fl[3], dc[3];   // index 0 cell, 1 fail, 2 run
  int ms, mhold, mblk, mfail;
  logic e_ce = 1'b1, e_we = 1'b1, e_oe = 1'b1, e_dq = 1'b0, e_src = 1'b1;

  always @(posedge clk) begin
    int raw[3];
    int nx, pass, hwr, hrd, up;
    raw[0] = f_cell; raw[1] = f_fail; raw[2] = f_run;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin s1[i] = 0; s2[i] = 0; fl[i] = 0; dc[i] = 0; end
      ms = 2; mhold = 0; mblk = 0; mfail = 0;
      e_ce = 1; e_we = 1; e_oe = 1; e_dq = 0; e_src = 1;
    end else begin
      up = fl[1] && fl[2];
      nx = ms;
      case (ms)
        0: if (!fl[0]) nx = 2; else if (!up) nx = 1;
        1: if (!fl[0]) nx = 2; else if (up) nx = 3;
        2: if (fl[0]) nx = 1;
        default: if (!fl[0]) nx = 2; else if (!up) nx = 1; else if (mhold == HOLD-1) nx = 0;
      endcase
      pass = (nx == 0);
      hwr = (!ce_n && !we_n);
      hrd = (!ce_n && we_n && !oe_n);
      e_ce  = !(pass && !ce_n);
      e_we  = !(pass && hwr && !mblk);
      e_oe  = !(pass && hrd);
      e_dq  = (pass && hrd);
      e_src = (nx == 2);
      mblk  = hwr && (mblk || !pass);
      if (ms == 0 && nx != 0) mfail = 1;
      mhold = (ms == 3 && nx == 3) ? mhold + 1 : 0;
      ms = nx;
      for (int i = 0; i < 3; i++) begin
        if (s2[i] == fl[i]) dc[i] = 0;
        else if (dc[i] == DEB-1) begin fl[i] = s2[i]; dc[i] = 0; end
        else dc[i] = dc[i] + 1;
        s2[i] = s1[i];
        s1[i] = raw[i];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(mem_ce_n === e_ce, "R3 mem_ce_n", mem_ce_n, e_ce);
      chk(mem_we_n === e_we, "R4/R9 mem_we_n", mem_we_n, e_we);
      chk(mem_oe_n === e_oe, "R5 mem_oe_n", mem_oe_n, e_oe);
      chk(dq_drive === e_dq, "R3 dq_drive", dq_drive, e_dq);
      chk(src_cell === e_src, "R6 src_cell", src_cell, e_src);
      chk(int'(state_o) == ms, "R8 state", state_o, ms);
      chk(int'(fail_seen) == mfail, "R10 fail_seen", fail_seen, mfail);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host(input logic c, input logic w, input logic o);
    ce_n = c; we_n = w; oe_n = o;
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    // R1: reset values
    chk(state_o == 2'd2, "R1 state", state_o, 2);
    chk(src_cell == 1'b1 && mem_we_n && mem_ce_n && mem_oe_n && !dq_drive && !fail_seen,
        "R1 outputs", {src_cell, mem_we_n, mem_ce_n, mem_oe_n, dq_drive, fail_seen}, 6'b111100);

    // power up
    f_cell = 1; cyc(2); f_fail = 1; cyc(2); f_run = 1;
    cyc(HOLD + 20);
    chk(state_o == 2'd0, "R8 reach NORMAL", state_o, 0);
    chk(fail_seen == 1'b0, "R10 no event on power-up", fail_seen, 0);

    // R3: access patterns
    host(0, 1, 0); cyc(2);
    chk(!mem_oe_n && dq_drive, "R3 read", {mem_oe_n, dq_drive}, 2'b01);
    host(0, 0, 0); cyc(2);
    chk(!mem_we_n && !dq_drive, "R3 write beats oe", {mem_we_n, dq_drive}, 2'b00);
    host(1, 0, 0); cyc(2);
    chk(mem_ce_n && mem_we_n, "R3 deselect", {mem_ce_n, mem_we_n}, 2'b11);
    host(1, 1, 1); cyc(1); host(0, 1, 1); cyc(1); host(0, 0, 1); cyc(2);
    chk(!mem_we_n, "R3 write after ce", mem_we_n, 0);
    host(1, 1, 1); cyc(2);

    // R2: short glitch on fail flag ignored
    f_fail = 0; cyc(DEB - 1); f_fail = 1; cyc(12);
    chk(state_o == 2'd0 && !fail_seen, "R2 glitch ignored", state_o, 0);

    // R4/R10: drop during held write
    host(0, 0, 1); cyc(3);
    chk(!mem_we_n, "R4 write active", mem_we_n, 0);
    f_run = 0; cyc(SYNC + DEB + 3);
    chk(state_o == 2'd1 && mem_we_n, "R4 aborted", {state_o, mem_we_n}, 3'b011);
    chk(fail_seen, "R10 sticky set", fail_seen, 1);

    // R9: host keeps write held across recovery
    f_run = 1; cyc(HOLD + 20);
    chk(state_o == 2'd0, "R9 back to NORMAL", state_o, 0);
    chk(mem_we_n, "R9 held write stays blocked", mem_we_n, 1);
    host(0, 1, 1); cyc(2); host(0, 0, 1); cyc(2);
    chk(!mem_we_n, "R9 fresh write forwarded", mem_we_n, 0);
    host(1, 1, 1); cyc(2);

    // R5/R6/R7: collapse to backup and partial rises
    f_run = 0; cyc(2); f_fail = 0; cyc(10);
    host(0, 1, 0); cyc(2);
    chk(mem_oe_n && !dq_drive && mem_ce_n, "R5 read blocked", {mem_oe_n, dq_drive}, 2'b10);
    host(1, 1, 1);
    f_cell = 0; cyc(SYNC + DEB + 3);
    chk(state_o == 2'd2 && src_cell, "R6 backup", {state_o, src_cell}, 3'b101);
    f_cell = 1; cyc(SYNC + DEB + 3);
    chk(state_o == 2'd1 && !src_cell, "R6 cell regained", {state_o, src_cell}, 3'b010);
    cyc(10);
    chk(state_o == 2'd1, "R7 cell alone stays PROTECT", state_o, 1);
    f_fail = 1; cyc(15);
    chk(state_o == 2'd1, "R7 fail without run stays PROTECT", state_o, 1);

    // R8: drop during RECOVER
    f_run = 1; cyc(SYNC + DEB + 3);
    chk(state_o == 2'd3, "R8 in RECOVER", state_o, 3);
    f_fail = 0; cyc(SYNC + DEB + 3);
    chk(state_o == 2'd1, "R8 drop in RECOVER", state_o, 1);
    f_fail = 1; cyc(HOLD + 20);
    chk(state_o == 2'd0, "R8 final NORMAL", state_o, 0);

    // R10: sticky until reset
    chk(fail_seen, "R10 still set", fail_seen, 1);
    rst = 1'b1; cyc(2);
    chk(!fail_seen && state_o == 2'd2, "R1/R10 cleared by reset", {fail_seen, state_o}, 3'b010);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule